// File: doc/BRIEF.md
# Synchronous Termination Latency Pipeline

This block sits on the memory side of a DDR3 device. It turns the termination request pin into a delayed internal termination enable. On every rising clock edge it samples the request pin. It then replays that sample a programmed number of cycles later on `rtt_on`, and drives `hi_z` as the complement of the enable. The delay is not fixed. It is derived from the CAS write latency and the additive-latency code, so the termination follows the write latency that the controller has set up in the mode registers.

The pipeline runs only while the device is in synchronous termination mode. That mode needs the DLL locked, at least one termination value enabled, and a power state in which the clock is still honoured. Outside that mode the block raises `async_mode`, forces the enable off and empties its pipeline. A change of latency is absorbed only while the request pin is low and no high sample is in flight. This keeps the tap from jumping under a live pulse.

Top module: `odt_latency_pipe`

## Requirements
- R1: `async_mode` is low exactly when `dll_locked` is high, at least one of `rtt_nom_en`/`rtt_wr_en` is high, and the power state allows synchronous operation. With `cke` high it always does. With `cke` low and `bank_open` high (active power-down) it does regardless of `dll_pd_on`. With `cke` low and `bank_open` low (precharge power-down) it does only when `dll_pd_on` is high.
- R2: The 2-bit `al_code` gives the additive latency: 2'b00 gives 0, 2'b01 gives `cl`−1, 2'b10 gives `cl`−2, and 2'b11 gives 0.
- R3: The termination latency is `cwl` + AL − 2, clamped to the range 1 to MAX_CWL + MAX_CL − 3 (25 with the defaults).
- R4: In synchronous mode, `rtt_on` goes high after the rising edge that comes a latency's number of edges after the edge that sampled `odt_pin` high. Every edge in that span must be synchronous.
- R5: Turn-off uses the same latency. `rtt_on` after edge t equals the pin value sampled at edge t − latency.
- R6: An edge taken outside synchronous mode empties the pipeline. Samples taken before it never reach `rtt_on`, and `rtt_on` is low while `async_mode` is high.
- R7: A new latency takes effect only at an edge where `odt_pin` is low and no high sample is held in the pipeline. Otherwise the previous latency stays in force.
- R8: While `rst_n` is low at a rising edge, the pipeline is emptied, `rtt_on` is low afterwards, and the latency is loaded from the current configuration.
- R9: `hi_z` is always the inverse of `rtt_on`.
- R10: `al_err` is high exactly when `al_code` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| odt_pin | input | 1 | External termination request |
| dll_locked | input | 1 | DLL on and locked |
| rtt_nom_en | input | 1 | Nominal termination value enabled |
| rtt_wr_en | input | 1 | Write termination value enabled |
| cke | input | 1 | Clock enable; low means power-down |
| bank_open | input | 1 | At least one bank active |
| dll_pd_on | input | 1 | DLL kept running in precharge power-down |
| al_code | input | 2 | Additive-latency code |
| cl | input | 5 | CAS latency in cycles |
| cwl | input | 4 | CAS write latency in cycles |
| rtt_on | output | 1 | Delayed termination enable |
| hi_z | output | 1 | Termination released (inverse of `rtt_on`) |
| async_mode | output | 1 | Synchronous conditions not met |
| al_err | output | 1 | Reserved additive-latency code selected |

## Verification
The assertions take for granted that configuration inputs change only between clock edges and stay stable across each edge. They also assume `odt_pin` is a clean level sampled once per edge. The bench drives every input on the falling edge, so each rising edge sees settled values. It picks `cwl` and `cl` inside the supported maxima, except for one directed step that pushes the sum below the minimum to exercise the clamp. The random phase changes the configuration at arbitrary points, even while pulses are in flight. This is legal because the latency-hold rule makes such changes safe, and the bench model applies the same rule when it works out which latency is in force.

// File: rtl/odt_pkg.sv
package odt_pkg;

  typedef enum logic [1:0] {
    AL_ZERO  = 2'b00,
    AL_CL_M1 = 2'b01,
    AL_CL_M2 = 2'b10,
    AL_RSVD  = 2'b11
  } al_code_e;

  // Additive latency in cycles for a given code and CAS latency.
  function automatic int decode_al(input logic [1:0] code, input int cas_lat);
    int al;
    case (code)
      AL_CL_M1: al = (cas_lat > 1) ? cas_lat - 1 : 0;
      AL_CL_M2: al = (cas_lat > 2) ? cas_lat - 2 : 0;
      default:  al = 0;
    endcase
    return al;
  endfunction

  // Termination latency: write latency minus two, kept inside [1, max_lat].
  function automatic int term_latency(input int cwl_cyc, input int al_cyc, input int max_lat);
    int lat;
    lat = cwl_cyc + al_cyc - 2;
    if (lat < 1)       lat = 1;
    if (lat > max_lat) lat = max_lat;
    return lat;
  endfunction

endpackage

// File: rtl/odt_mode_detect.sv
module odt_mode_detect (
  input  logic dll_locked,
  input  logic rtt_nom_en,
  input  logic rtt_wr_en,
  input  logic cke,
  input  logic bank_open,
  input  logic dll_pd_on,
  output logic sync_mode
);

  logic term_enabled;
  logic clocked_state;

  assign term_enabled = rtt_nom_en | rtt_wr_en;

  // Active states and active power-down keep the clock path alive;
  // precharge power-down does so only with the DLL kept running.
  always_comb begin
    if (cke)            clocked_state = 1'b1;
    else if (bank_open) clocked_state = 1'b1;
    else                clocked_state = dll_pd_on;
  end

  assign sync_mode = dll_locked & term_enabled & clocked_state;

endmodule

// File: rtl/odt_latency_calc.sv
module odt_latency_calc #(
  parameter int CWL_W   = 4,
  parameter int CL_W    = 5,
  parameter int LAT_W   = 5,
  parameter int MAX_LAT = 25
) (
  input  logic [CWL_W-1:0] cwl,
  input  logic [CL_W-1:0]  cl,
  input  logic [1:0]       al_code,
  output logic [CL_W-1:0]  al_val,
  output logic [LAT_W-1:0] lat_calc,
  output logic             al_err
);

  int al_cyc;
  int lat_cyc;

  always_comb begin
    al_cyc   = odt_pkg::decode_al(al_code, int'(cl));
    lat_cyc  = odt_pkg::term_latency(int'(cwl), al_cyc, MAX_LAT);
    al_val   = CL_W'(al_cyc);
    lat_calc = LAT_W'(lat_cyc);
  end

  assign al_err = (al_code == odt_pkg::AL_RSVD);

endmodule

// File: rtl/odt_delay_line.sv
module odt_delay_line #(
  parameter int DEPTH = 26,
  parameter int LAT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_mode,
  input  logic             odt_in,
  input  logic [LAT_W-1:0] lat_calc,
  output logic [LAT_W-1:0] lat_q,
  output logic             pipe_any,
  output logic             tap_out
);

  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] tap_sel;
  logic             lat_load;

  assign pipe_any = |stage_q;
  assign lat_load = ~odt_in & ~pipe_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (!sync_mode) begin
      stage_q <= '0;
    end else begin
      stage_q <= {stage_q[DEPTH-2:0], odt_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        lat_q <= lat_calc;
    else if (lat_load) lat_q <= lat_calc;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    assign tap_sel[i] = (lat_q == LAT_W'(i));
  end

  assign tap_out = |(tap_sel & stage_q);

endmodule

// File: rtl/odt_latency_pipe.sv
module odt_latency_pipe #(
  parameter int MAX_CWL = 12,
  parameter int MAX_CL  = 16,
  parameter int CWL_W   = $clog2(MAX_CWL + 1),
  parameter int CL_W    = $clog2(MAX_CL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             odt_pin,
  input  logic             dll_locked,
  input  logic             rtt_nom_en,
  input  logic             rtt_wr_en,
  input  logic             cke,
  input  logic             bank_open,
  input  logic             dll_pd_on,
  input  logic [1:0]       al_code,
  input  logic [CL_W-1:0]  cl,
  input  logic [CWL_W-1:0] cwl,
  output logic             rtt_on,
  output logic             hi_z,
  output logic             async_mode,
  output logic             al_err
);

  localparam int MAX_LAT = MAX_CWL + MAX_CL - 3;
  localparam int DEPTH   = MAX_LAT + 1;
  localparam int LAT_W   = $clog2(DEPTH);

  logic             sync_mode;
  logic [CL_W-1:0]  al_val;
  logic [LAT_W-1:0] lat_calc;
  logic [LAT_W-1:0] lat_q;
  logic             pipe_any;
  logic             tap_out;

  odt_mode_detect u_mode (
    .dll_locked (dll_locked),
    .rtt_nom_en (rtt_nom_en),
    .rtt_wr_en  (rtt_wr_en),
    .cke        (cke),
    .bank_open  (bank_open),
    .dll_pd_on  (dll_pd_on),
    .sync_mode  (sync_mode)
  );

  odt_latency_calc #(
    .CWL_W   (CWL_W),
    .CL_W    (CL_W),
    .LAT_W   (LAT_W),
    .MAX_LAT (MAX_LAT)
  ) u_calc (
    .cwl      (cwl),
    .cl       (cl),
    .al_code  (al_code),
    .al_val   (al_val),
    .lat_calc (lat_calc),
    .al_err   (al_err)
  );

  odt_delay_line #(
    .DEPTH (DEPTH),
    .LAT_W (LAT_W)
  ) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_mode (sync_mode),
    .odt_in    (odt_pin),
    .lat_calc  (lat_calc),
    .lat_q     (lat_q),
    .pipe_any  (pipe_any),
    .tap_out   (tap_out)
  );

  assign rtt_on     = sync_mode & tap_out;
  assign hi_z       = ~rtt_on;
  assign async_mode = ~sync_mode;

endmodule

// File: rtl/odt_latency_chk.sv
module odt_latency_chk #(
  parameter int LAT_W = 5,
  parameter int CL_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             odt_pin,
  input logic             rtt_on,
  input logic             hi_z,
  input logic             async_mode,
  input logic             al_err,
  input logic             pipe_any,
  input logic [LAT_W-1:0] lat_q,
  input logic [CL_W-1:0]  al_val
);

  logic rst_seen;

  always_ff @(posedge clk) rst_seen <= ~rst_n;

  always @(negedge clk) begin
    if (rst_seen === 1'b1) begin
      p_reset_off_r8: assert (rtt_on == 1'b0);
    end
  end

  p_async_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    async_mode |-> !rtt_on);

  p_async_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    async_mode |=> !pipe_any);

  p_rise_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rtt_on |-> $past(pipe_any));

  p_lat_hold_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    odt_pin |=> $stable(lat_q));

  p_lat_hold_pipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_any |=> $stable(lat_q));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    al_err |-> (al_val == '0));

  p_hiz_inv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hi_z != rtt_on);

endmodule

bind odt_latency_pipe odt_latency_chk #(
  .LAT_W (LAT_W),
  .CL_W  (CL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .odt_pin    (odt_pin),
  .rtt_on     (rtt_on),
  .hi_z       (hi_z),
  .async_mode (async_mode),
  .al_err     (al_err),
  .pipe_any   (pipe_any),
  .lat_q      (lat_q),
  .al_val     (al_val)
);

// File: tb/odt_latency_pipe_test.sv
module odt_latency_pipe_test;

  localparam int CLK_P   = 10;
  localparam int MAXLAT  = 25;
  localparam int NSTAGE  = MAXLAT + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       odt_pin = 1'b0;
  logic       dll_locked = 1'b1;
  logic       rtt_nom_en = 1'b1;
  logic       rtt_wr_en = 1'b0;
  logic       cke = 1'b1;
  logic       bank_open = 1'b0;
  logic       dll_pd_on = 1'b0;
  logic [1:0] al_code = 2'b00;
  logic [4:0] cl = 5'd6;
  logic [3:0] cwl = 4'd5;
  logic       rtt_on, hi_z, async_mode, al_err;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 1'b0;
  string cur_tag  = "R4";

  bit    hist [64];
  int    edge_no = 0;
  int    run_len = 0;
  int    lat_mdl = 3;
  bit    exp_rtt = 1'b0;
  bit    exp_syn = 1'b0;

  odt_latency_pipe uut (
    .clk(clk), .rst_n(rst_n), .odt_pin(odt_pin), .dll_locked(dll_locked),
    .rtt_nom_en(rtt_nom_en), .rtt_wr_en(rtt_wr_en), .cke(cke),
    .bank_open(bank_open), .dll_pd_on(dll_pd_on), .al_code(al_code),
    .cl(cl), .cwl(cwl), .rtt_on(rtt_on), .hi_z(hi_z),
    .async_mode(async_mode), .al_err(al_err)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int want_al(input int code, input int cas);
    if (code == 1) return (cas >= 1) ? cas - 1 : 0;
    if (code == 2) return (cas >= 2) ? cas - 2 : 0;
    return 0;
  endfunction

  function automatic int want_lat(input int w, input int a);
    int v = w + a - 2;
    return (v < 1) ? 1 : ((v > MAXLAT) ? MAXLAT : v);
  endfunction

  function automatic bit want_sync();
    bit state_ok = cke || bank_open || dll_pd_on;
    return dll_locked && (rtt_nom_en || rtt_wr_en) && state_ok;
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit s, empty;
    int cfg_lat;
    s       = want_sync();
    cfg_lat = want_lat(int'(cwl), want_al(int'(al_code), int'(cl)));
    @(posedge clk);
    if (!rst_n) begin
      run_len = 0;
      lat_mdl = cfg_lat;
      exp_rtt = 1'b0;
    end else begin
      empty = 1'b1;
      for (int k = 1; k <= NSTAGE; k++)
        if (k <= run_len && hist[(edge_no - k) & 63]) empty = 1'b0;
      if (!odt_pin && empty) lat_mdl = cfg_lat;
      if (s) begin if (run_len < 1000) run_len++; end
      else run_len = 0;
      hist[edge_no & 63] = odt_pin;
      exp_rtt = s && (run_len >= lat_mdl + 1) && hist[(edge_no - lat_mdl) & 63];
    end
    exp_syn = s;
    edge_no++;
    #1;
    check(rst_n ? cur_tag : "R8", "rtt_on", rtt_on, exp_rtt);
    check("R9", "hi_z", hi_z, ~exp_rtt);
    check("R1", "async_mode", async_mode, ~exp_syn);
    check("R10", "al_err", al_err, al_code == 2'b11);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse(input int hi, input int lo);
    odt_pin = 1'b1; ticks(hi);
    odt_pin = 1'b0; ticks(lo);
  endtask

  task automatic set_cfg(input int w, input int c, input int code);
    cwl = 4'(w); cl = 5'(c); al_code = 2'(code);
  endtask

  initial begin
    int unsigned seed0;
    seed0 = $urandom(32'd20240611);
    // reset state
    cur_tag = "R8";
    ticks(3);
    @(negedge clk);
    rst_n = 1'b1;
    // basic latency, turn-on and turn-off
    cur_tag = "R4"; pulse(4, 12);
    cur_tag = "R5"; pulse(1, 8); pulse(2, 2); pulse(3, 30);
    // additive latency codes, settled with pin low and empty pipeline
    cur_tag = "R2"; set_cfg(6, 8, 1); ticks(2); pulse(3, 30);
    set_cfg(7, 9, 2); ticks(2); pulse(5, 30);
    cur_tag = "R10"; set_cfg(8, 10, 3); ticks(2); pulse(2, 30);
    // latency clamps
    cur_tag = "R3"; set_cfg(2, 6, 0); ticks(2); pulse(2, 10);
    set_cfg(12, 16, 1); ticks(2); pulse(4, 40);
    // latency change requested under a live pulse
    cur_tag = "R7"; set_cfg(5, 6, 0); ticks(30);
    odt_pin = 1'b1; ticks(1);
    set_cfg(5, 6, 1); ticks(3);
    odt_pin = 1'b0; ticks(40); pulse(2, 30);
    // leaving synchronous mode mid-burst
    cur_tag = "R6"; set_cfg(5, 6, 0); ticks(30);
    odt_pin = 1'b1; ticks(2);
    dll_locked = 1'b0; ticks(2); dll_locked = 1'b1;
    ticks(6); odt_pin = 1'b0; ticks(10);
    // power states
    cur_tag = "R1"; odt_pin = 1'b1;
    for (int m = 0; m < 8; m++) begin
      cke = m[0]; bank_open = m[1]; dll_pd_on = m[2]; ticks(8);
    end
    cke = 1'b1; rtt_nom_en = 1'b0; rtt_wr_en = 1'b1; ticks(8);
    rtt_wr_en = 1'b0; ticks(6);
    rtt_nom_en = 1'b1; odt_pin = 1'b0; ticks(30);
    // constrained random
    cur_tag = "R5";
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(99) < 3)
        set_cfg(int'($urandom_range(12, 5)), int'($urandom_range(16, 5)),
                int'($urandom_range(3)));
      if ($urandom_range(99) < 20) odt_pin = ~odt_pin;
      dll_locked = ($urandom_range(99) < 97);
      cke        = ($urandom_range(99) < 85);
      bank_open  = $urandom_range(1);
      dll_pd_on  = $urandom_range(1);
      tick();
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

endmodule